// File: doc/BRIEF.md
# Copy Descriptor Checker with Status Writeback

This block sits between a descriptor fetch unit and a memory-to-memory copy engine. It receives one fetched 32-byte copy descriptor as eight 32-bit words. It screens the descriptor's control word, its incoming status byte, the length, the two addresses and the address width. It then either hands a copy command to the data mover or skips the copy and reports an error code at once. When the mover answers, the block builds the 32-bit word that goes back into the descriptor's second word. That word holds a status byte, an error byte and the descriptor's 16-bit identifier. With the word it pulses an error flag for the queue controller or an interrupt request.

The descriptor layout is fixed as follows:

- Word 0 is control. Bit 0 marks the start of a chain. Bit 1 requests an interrupt on completion. Bits 5:4 give the destination memory type and bits 7:6 give the source memory type, with 0 for memory and 1 for I/O. All other bits must be zero.
- Word 1 carries a status byte in bits 7:0, an error byte in bits 15:8 and an identifier in bits 31:16.
- Word 2 is the byte length and word 3 is unused.
- Source low and high halves are words 4 and 5. Destination low and high halves are words 6 and 7. Only bits 15:0 of each high half are address bits, which gives 48-bit addresses.
- Input word i occupies bits 32*i+31 to 32*i of `desc_data`.

The controller is a five-state machine:

- `ST_IDLE`: ready. A valid descriptor moves it to `ST_CHECK`.
- `ST_CHECK`: the captured descriptor is screened. A failure moves to `ST_REPORT`. A clean descriptor moves to `ST_ISSUE`.
- `ST_ISSUE`: one cycle of `cmd_valid`, then `ST_WAIT`.
- `ST_WAIT`: holds until the mover reports done or error, then `ST_REPORT`.
- `ST_REPORT`: one cycle of writeback, then `ST_IDLE`.

Top module: `desc_check_wb`

## Requirements
- R1: After reset `desc_ready` is 1 and `cmd_valid`, `wb_valid`, `desc_err` and `irq_req` are 0.
- R2: A control word with any of bits 31:8 or 3:2 set, or with a memory-type field (bits 5:4 or 7:6) above 1, is rejected with error code 1.
- R3: A descriptor whose incoming status byte (word 1 bits 7:0) is nonzero is rejected with error code 2.
- R4: A length (word 2) that is not a multiple of 4 is rejected with error code 3.
- R5: A source low half (word 4) with bits 1:0 nonzero is rejected with code 4. A destination low half (word 6) with bits 1:0 nonzero is rejected with code 5.
- R6: A source or destination high half (word 5 or word 7) with any of bits 31:16 set is rejected with error code 7.
- R7: Checks rank in this order: header, status, length, source, destination, width. Only the first failing code is reported. A rejected descriptor never raises `cmd_valid`, and its writeback appears for one cycle after the second rising edge counted from the accepting edge.
- R8: For a clean descriptor, `cmd_valid` is high for exactly one cycle after the second rising edge counted from the accepting edge. At the same time `cmd_src` = {word5[15:0], word4}, `cmd_dst` = {word7[15:0], word6}, `cmd_len` = word 2, `cmd_src_type` = word0[7:6] and `cmd_dst_type` = word0[5:4].
- R9: A successful copy writes back {identifier, 8'h00, 8'h03}. `irq_req` is high with `wb_valid` exactly when control bit 1 is set.
- R10: A mover error writes back status 8'h02 with the mover's code, raised to 64 if it is below 64. When done and error arrive in the same cycle, the error wins.
- R11: Every rejected or failed descriptor writes back status 8'h02 and pulses `desc_err` together with `wb_valid`. `desc_err` and `irq_req` are never high without `wb_valid`, and `irq_req` is never high on an error.
- R12: `desc_ready` is low from the accepting edge until the writeback cycle ends. A `desc_valid` while busy is ignored, and so are mover responses outside `ST_WAIT`: neither produces an extra command or writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Fetched descriptor present |
| desc_data | input | 256 | Eight descriptor words, word i at bits 32*i+31:32*i |
| desc_ready | output | 1 | Block idle, descriptor accepted this cycle if valid |
| cmd_valid | output | 1 | One-cycle copy launch |
| cmd_src | output | 48 | Source byte address |
| cmd_dst | output | 48 | Destination byte address |
| cmd_len | output | 32 | Copy length in bytes |
| cmd_src_type | output | 2 | Source memory type |
| cmd_dst_type | output | 2 | Destination memory type |
| mover_done | input | 1 | Copy finished cleanly |
| mover_err | input | 1 | Copy failed |
| mover_code | input | 8 | Failure reason from the mover |
| wb_valid | output | 1 | Writeback word present (one cycle) |
| wb_word | output | 32 | Identifier, error byte, status byte |
| desc_err | output | 1 | Error pulse to the queue controller |
| irq_req | output | 1 | Completion interrupt pulse |

## Verification
The mover's clean and failed responses can reach the waiting state in the same cycle. The bench provokes this by raising `mover_done` and `mover_err` together with a code of 0x90, and expects a failure writeback carrying 0x90, a `desc_err` pulse and no interrupt. A second overlap is a response that lands in the cycle the command is issued, together with a new descriptor offered while the block waits. The bench judges that overlap by seeing no writeback until the real response comes, followed by exactly one writeback for the original descriptor.

// File: rtl/dv_pkg.sv
package dv_pkg;
    localparam int DW     = 32;
    localparam int NWORDS = 8;

    // Word slots inside a descriptor
    localparam int W_CTRL   = 0;
    localparam int W_STAT   = 1;
    localparam int W_LEN    = 2;
    localparam int W_RSVD   = 3;
    localparam int W_SRC_LO = 4;
    localparam int W_SRC_HI = 5;
    localparam int W_DST_LO = 6;
    localparam int W_DST_HI = 7;

    localparam int B_IOC = 1;

    localparam logic [7:0] STS_OK   = 8'h03;
    localparam logic [7:0] STS_FAIL = 8'h02;

    localparam logic [7:0] E_NONE  = 8'd0;
    localparam logic [7:0] E_HDR   = 8'd1;
    localparam logic [7:0] E_STAT  = 8'd2;
    localparam logic [7:0] E_LEN   = 8'd3;
    localparam logic [7:0] E_SRC   = 8'd4;
    localparam logic [7:0] E_DST   = 8'd5;
    localparam logic [7:0] E_WIDTH = 8'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_REPORT
    } dv_state_e;

    // Raise a mover failure code into the translation-error range
    function automatic logic [7:0] lift_code(input logic [7:0] raw,
                                             input logic [7:0] floor_c);
        return (raw < floor_c) ? floor_c : raw;
    endfunction
endpackage

// File: rtl/dv_check.sv
module dv_check
    import dv_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int ALIGN_BYTES = 4
) (
    input  logic [DW-1:0] ctrl,
    input  logic [7:0]    stat_b,
    input  logic [DW-1:0] len,
    input  logic [DW-1:0] src_lo,
    input  logic [DW-1:0] src_hi,
    input  logic [DW-1:0] dst_lo,
    input  logic [DW-1:0] dst_hi,
    output logic [7:0]    code
);
    localparam int HI_W = ADDR_W - DW;
    localparam int AL   = $clog2(ALIGN_BYTES);

    logic hdr_bad, len_mis, src_mis, dst_mis, wide_bad;

    assign hdr_bad = (|ctrl[DW-1:8]) | (|ctrl[3:2]) | ctrl[5] | ctrl[7];

    generate
        if (AL > 0) begin : g_align
            assign len_mis = |len[AL-1:0];
            assign src_mis = |src_lo[AL-1:0];
            assign dst_mis = |dst_lo[AL-1:0];
        end else begin : g_no_align
            assign len_mis = 1'b0;
            assign src_mis = 1'b0;
            assign dst_mis = 1'b0;
        end

        if (HI_W < DW) begin : g_width
            assign wide_bad = (|src_hi[DW-1:HI_W]) | (|dst_hi[DW-1:HI_W]);
        end else begin : g_full_width
            assign wide_bad = 1'b0;
        end
    endgenerate

    // Fixed rank: first failing check wins
    always_comb begin
        if (hdr_bad)             code = E_HDR;
        else if (stat_b != 8'd0) code = E_STAT;
        else if (len_mis)        code = E_LEN;
        else if (src_mis)        code = E_SRC;
        else if (dst_mis)        code = E_DST;
        else if (wide_bad)       code = E_WIDTH;
        else                     code = E_NONE;
    end

    logic unused_bits;
    assign unused_bits = ^{len, src_lo, dst_lo, src_hi, dst_hi, ctrl[6], ctrl[4], ctrl[1:0]};
endmodule

// File: rtl/dv_ctrl.sv
module dv_ctrl
    import dv_pkg::*;
#(
    parameter logic [7:0] XLAT_MIN = 8'd64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       desc_valid,
    input  logic [7:0] chk_code,
    input  logic       mover_done,
    input  logic       mover_err,
    input  logic [7:0] mover_code,
    output logic       ready,
    output logic       load,
    output logic       issue,
    output logic       report,
    output logic       fail_q,
    output logic [7:0] code_q
);
    dv_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (desc_valid) nxt = ST_CHECK;
            ST_CHECK:  nxt = (chk_code != E_NONE) ? ST_REPORT : ST_ISSUE;
            ST_ISSUE:  nxt = ST_WAIT;
            ST_WAIT:   if (mover_done || mover_err) nxt = ST_REPORT;
            ST_REPORT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = 1'b0;
        issue  = 1'b0;
        report = 1'b0;
        unique case (state)
            ST_IDLE:   ready  = 1'b1;
            ST_CHECK:  ;
            ST_ISSUE:  issue  = 1'b1;
            ST_WAIT:   ;
            ST_REPORT: report = 1'b1;
            default:   ;
        endcase
    end

    assign load = ready & desc_valid;

    // Outcome register: screening result or mover result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            code_q <= E_NONE;
        end else if (state == ST_CHECK) begin
            fail_q <= (chk_code != E_NONE);
            code_q <= chk_code;
        end else if (state == ST_WAIT && mover_err) begin
            fail_q <= 1'b1;
            code_q <= lift_code(mover_code, XLAT_MIN);
        end else if (state == ST_WAIT && mover_done) begin
            fail_q <= 1'b0;
            code_q <= E_NONE;
        end
    end

    // R7: a rejected descriptor goes straight to writeback with its code
    a_r7_reject_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && chk_code != E_NONE) |=>
            (state == ST_REPORT && fail_q && code_q == $past(chk_code)));

    // R10: a mover error wins over a simultaneous done
    a_r10_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mover_err) |=> (fail_q && code_q >= XLAT_MIN));

    // R12: responses outside the waiting state do not end the copy
    a_r12_issue_ignores_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |=> (state == ST_WAIT));
endmodule

// File: rtl/dv_wb.sv
module dv_wb
    import dv_pkg::*;
(
    input  logic        report,
    input  logic        fail,
    input  logic [7:0]  code,
    input  logic [15:0] id,
    input  logic        ioc,
    output logic        wb_valid,
    output logic [31:0] wb_word,
    output logic        desc_err,
    output logic        irq_req
);
    always_comb begin
        wb_valid = report;
        wb_word  = {id, (fail ? code : 8'h00), (fail ? STS_FAIL : STS_OK)};
        desc_err = report & fail;
        irq_req  = report & ~fail & ioc;
    end
endmodule

// File: rtl/desc_check_wb.sv
module desc_check_wb
    import dv_pkg::*;
#(
    parameter int         ADDR_W      = 48,
    parameter int         ALIGN_BYTES = 4,
    parameter logic [7:0] XLAT_MIN    = 8'd64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_valid,
    input  logic [DW*NWORDS-1:0] desc_data,
    output logic                 desc_ready,
    output logic                 cmd_valid,
    output logic [ADDR_W-1:0]    cmd_src,
    output logic [ADDR_W-1:0]    cmd_dst,
    output logic [DW-1:0]        cmd_len,
    output logic [1:0]           cmd_src_type,
    output logic [1:0]           cmd_dst_type,
    input  logic                 mover_done,
    input  logic                 mover_err,
    input  logic [7:0]           mover_code,
    output logic                 wb_valid,
    output logic [31:0]          wb_word,
    output logic                 desc_err,
    output logic                 irq_req
);
    localparam int HI_W = ADDR_W - DW;

    logic [DW*NWORDS-1:0] desc_q;
    logic [DW-1:0]        word [NWORDS];
    logic                 load, issue, report, fail_q;
    logic [7:0]           chk_code, code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    desc_q <= '0;
        else if (load) desc_q <= desc_data;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NWORDS; gi++) begin : g_words
            assign word[gi] = desc_q[gi*DW +: DW];
        end
    endgenerate

    dv_check #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_check (
        .ctrl   (word[W_CTRL]),
        .stat_b (word[W_STAT][7:0]),
        .len    (word[W_LEN]),
        .src_lo (word[W_SRC_LO]),
        .src_hi (word[W_SRC_HI]),
        .dst_lo (word[W_DST_LO]),
        .dst_hi (word[W_DST_HI]),
        .code   (chk_code)
    );

    dv_ctrl #(.XLAT_MIN(XLAT_MIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .chk_code   (chk_code),
        .mover_done (mover_done),
        .mover_err  (mover_err),
        .mover_code (mover_code),
        .ready      (desc_ready),
        .load       (load),
        .issue      (issue),
        .report     (report),
        .fail_q     (fail_q),
        .code_q     (code_q)
    );

    dv_wb u_wb (
        .report   (report),
        .fail     (fail_q),
        .code     (code_q),
        .id       (word[W_STAT][31:16]),
        .ioc      (word[W_CTRL][B_IOC]),
        .wb_valid (wb_valid),
        .wb_word  (wb_word),
        .desc_err (desc_err),
        .irq_req  (irq_req)
    );

    assign cmd_valid    = issue;
    assign cmd_src      = {word[W_SRC_HI][HI_W-1:0], word[W_SRC_LO]};
    assign cmd_dst      = {word[W_DST_HI][HI_W-1:0], word[W_DST_LO]};
    assign cmd_len      = word[W_LEN];
    assign cmd_src_type = word[W_CTRL][7:6];
    assign cmd_dst_type = word[W_CTRL][5:4];

    logic unused_fields;
    assign unused_fields = ^{word[W_RSVD], word[W_STAT][15:8]};

    // R12: accepting a descriptor drops ready on the next cycle
    a_r12_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready) |=> !desc_ready);

    // R8: a launch lasts one cycle and carries aligned fields
    a_r8_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r8_cmd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len[1:0] == 2'b00 && cmd_src[1:0] == 2'b00 &&
                       cmd_dst[1:0] == 2'b00 && !cmd_src_type[1] && !cmd_dst_type[1]));

    // R11: error and interrupt flags only with a writeback, never together
    a_r11_err_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> (wb_valid && wb_word[7:0] == STS_FAIL));
    a_r11_irq_clean: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (wb_valid && !desc_err && wb_word[7:0] == STS_OK));

    // R12: no writeback and launch in the same cycle
    a_r12_wb_launch_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && cmd_valid));
endmodule

// File: tb/desc_check_wb_bench.sv
module desc_check_wb_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         desc_valid = 1'b0;
    logic [255:0] desc_data = '0;
    logic         desc_ready;
    logic         cmd_valid;
    logic [47:0]  cmd_src, cmd_dst;
    logic [31:0]  cmd_len;
    logic [1:0]   cmd_src_type, cmd_dst_type;
    logic         mover_done = 1'b0;
    logic         mover_err = 1'b0;
    logic [7:0]   mover_code = '0;
    logic         wb_valid;
    logic [31:0]  wb_word;
    logic         desc_err, irq_req;

    always #5 clk = ~clk;

    desc_check_wb u_desc_check_wb (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_data(desc_data),
        .desc_ready(desc_ready), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_len(cmd_len), .cmd_src_type(cmd_src_type),
        .cmd_dst_type(cmd_dst_type), .mover_done(mover_done), .mover_err(mover_err),
        .mover_code(mover_code), .wb_valid(wb_valid), .wb_word(wb_word),
        .desc_err(desc_err), .irq_req(irq_req)
    );

    typedef struct packed { logic [31:0] word; logic err; logic irq; } wb_t;
    typedef struct packed { logic [47:0] src; logic [47:0] dst; logic [31:0] len;
                            logic [1:0] st; logic [1:0] dt; } cmd_t;

    wb_t  wb_exp_q[$];
    cmd_t cmd_exp_q[$];
    wb_t  wb_e;
    cmd_t cmd_e;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard compare of launches and writebacks
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (wb_valid) begin
                if (wb_exp_q.size() == 0) chk(1'b0, "R12", "unexpected writeback", {32'h0, wb_word}, 64'h0);
                else begin
                    wb_e = wb_exp_q.pop_front();
                    chk(wb_word == wb_e.word, "R9", "scoreboard writeback word", {32'h0, wb_word}, {32'h0, wb_e.word});
                    chk(desc_err == wb_e.err, "R11", "scoreboard error flag", {63'h0, desc_err}, {63'h0, wb_e.err});
                    chk(irq_req == wb_e.irq, "R9", "scoreboard interrupt", {63'h0, irq_req}, {63'h0, wb_e.irq});
                end
            end else if (desc_err || irq_req) begin
                chk(1'b0, "R11", "flag without writeback", {62'h0, desc_err, irq_req}, 64'h0);
            end
            if (cmd_valid) begin
                if (cmd_exp_q.size() == 0) chk(1'b0, "R7", "unexpected launch", {16'h0, cmd_src}, 64'h0);
                else begin
                    cmd_e = cmd_exp_q.pop_front();
                    chk(cmd_src == cmd_e.src, "R8", "source", {16'h0, cmd_src}, {16'h0, cmd_e.src});
                    chk(cmd_dst == cmd_e.dst, "R8", "destination", {16'h0, cmd_dst}, {16'h0, cmd_e.dst});
                    chk(cmd_len == cmd_e.len, "R8", "length", {32'h0, cmd_len}, {32'h0, cmd_e.len});
                    chk({cmd_src_type, cmd_dst_type} == {cmd_e.st, cmd_e.dt}, "R8", "memory types",
                        {60'h0, cmd_src_type, cmd_dst_type}, {60'h0, cmd_e.st, cmd_e.dt});
                end
            end
        end
    end

    function automatic logic [7:0] exp_code(input logic [31:0] c, input logic [7:0] s,
                                            input logic [31:0] l, input logic [31:0] sl,
                                            input logic [31:0] sh, input logic [31:0] dl,
                                            input logic [31:0] dh);
        if (c[31:8] != 0 || c[3:2] != 0 || c[5:4] > 2'd1 || c[7:6] > 2'd1) return 8'd1;
        if (s != 8'd0)                                                      return 8'd2;
        if (l[1:0] != 0)                                                    return 8'd3;
        if (sl[1:0] != 0)                                                   return 8'd4;
        if (dl[1:0] != 0)                                                   return 8'd5;
        if (sh[31:16] != 0 || dh[31:16] != 0)                               return 8'd7;
        return 8'd0;
    endfunction

    // Driver: offers one descriptor, plays the mover, checks cycle timing
    // resp: 0 done, 1 error, 2 done and error together
    task automatic send(input string req, input logic [31:0] c, input logic [7:0] s,
                        input logic [15:0] id, input logic [31:0] l,
                        input logic [31:0] sl, input logic [31:0] sh,
                        input logic [31:0] dl, input logic [31:0] dh,
                        input int resp, input logic [7:0] rcode,
                        input int delay, input bit glitch);
        logic [7:0] code;
        wb_t w;
        cmd_t cm;
        code = exp_code(c, s, l, sl, sh, dl, dh);
        @(negedge clk);
        chk(desc_ready == 1'b1, "R12", "ready before offer", {63'h0, desc_ready}, 64'h1);
        desc_data  = {dh, dl, sh, sl, 32'hDEAD_BEEF, l, {id, 8'hA5, s}, c};
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        chk(desc_ready == 1'b0, "R12", "ready after accept", {63'h0, desc_ready}, 64'h0);
        if (code != 8'd0) begin
            w.word = {id, code, 8'h02}; w.err = 1'b1; w.irq = 1'b0;
            wb_exp_q.push_back(w);
            @(negedge clk);
            chk(wb_valid == 1'b1, req, "rejection writeback timing", {63'h0, wb_valid}, 64'h1);
            chk(wb_word[15:8] == code, req, "rejection code", {56'h0, wb_word[15:8]}, {56'h0, code});
            chk(cmd_valid == 1'b0, "R7", "no launch on rejection", {63'h0, cmd_valid}, 64'h0);
        end else begin
            cm.src = {sh[15:0], sl}; cm.dst = {dh[15:0], dl}; cm.len = l;
            cm.st = c[7:6]; cm.dt = c[5:4];
            cmd_exp_q.push_back(cm);
            @(negedge clk);
            chk(cmd_valid == 1'b1, "R8", "launch timing", {63'h0, cmd_valid}, 64'h1);
            if (glitch) mover_done = 1'b1;
            @(negedge clk);
            mover_done = 1'b0;
            chk(cmd_valid == 1'b0, "R8", "launch lasts one cycle", {63'h0, cmd_valid}, 64'h0);
            if (glitch) begin
                desc_data  = {8{32'h0000_FF01}};
                desc_valid = 1'b1;
                @(negedge clk);
                desc_valid = 1'b0;
                chk(desc_ready == 1'b0, "R12", "still busy while waiting", {63'h0, desc_ready}, 64'h0);
            end
            for (int k = 0; k < delay; k++) begin
                @(negedge clk);
                chk(wb_valid == 1'b0, "R12", "no writeback before response", {63'h0, wb_valid}, 64'h0);
            end
            if (resp == 0) begin
                w.word = {id, 8'h00, 8'h03}; w.err = 1'b0; w.irq = c[1];
            end else begin
                w.word = {id, (rcode < 8'd64) ? 8'd64 : rcode, 8'h02}; w.err = 1'b1; w.irq = 1'b0;
            end
            wb_exp_q.push_back(w);
            mover_code = rcode;
            mover_done = (resp != 1);
            mover_err  = (resp != 0);
            @(negedge clk);
            mover_done = 1'b0;
            mover_err  = 1'b0;
            chk(wb_valid == 1'b1, req, "completion writeback timing", {63'h0, wb_valid}, 64'h1);
            chk(wb_word == w.word, req, "completion word", {32'h0, wb_word}, {32'h0, w.word});
        end
        @(negedge clk);
        chk(desc_ready == 1'b1, "R12", "ready after writeback", {63'h0, desc_ready}, 64'h1);
        chk(wb_valid == 1'b0, "R12", "writeback lasts one cycle", {63'h0, wb_valid}, 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(desc_ready == 1'b1, "R1", "ready in reset", {63'h0, desc_ready}, 64'h1);
        chk({cmd_valid, wb_valid, desc_err, irq_req} == 4'b0, "R1", "outputs quiet in reset",
            {60'h0, cmd_valid, wb_valid, desc_err, irq_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 R9: clean copy with interrupt request
        send("R9", 32'h0000_0002, 8'h00, 16'h1234, 32'h0000_0400,
             32'h1000_0000, 32'h0000_00AB, 32'h2000_0040, 32'h0000_0CD0, 0, 8'h00, 2, 1'b0);
        // R8: I/O memory types, no interrupt
        send("R8", 32'h0000_0051, 8'h00, 16'h0042, 32'h0000_0010,
             32'h0000_0100, 32'h0000_FFFF, 32'h0000_0200, 32'h0000_0001, 0, 8'h00, 0, 1'b0);
        // R2: header faults
        send("R2", 32'h0000_0102, 8'h00, 16'h0001, 32'h10, 32'h0, 32'h0, 32'h0, 32'h0, 0, 8'h00, 0, 1'b0);
        send("R2", 32'h0000_0020, 8'h00, 16'h0002, 32'h10, 32'h0, 32'h0, 32'h0, 32'h0, 0, 8'h00, 0, 1'b0);
        send("R2", 32'h0000_000A, 8'h00, 16'h0003, 32'h10, 32'h0, 32'h0, 32'h0, 32'h0, 0, 8'h00, 0, 1'b0);
        // R3 R7: nonzero status outranks a bad length
        send("R3", 32'h0000_0002, 8'h03, 16'h0004, 32'h11, 32'h0, 32'h0, 32'h0, 32'h0, 0, 8'h00, 0, 1'b0);
        // R4
        send("R4", 32'h0000_0002, 8'h00, 16'h0005, 32'h101, 32'h0, 32'h0, 32'h0, 32'h0, 0, 8'h00, 0, 1'b0);
        // R5 R7: source outranks destination
        send("R5", 32'h0000_0002, 8'h00, 16'h0006, 32'h100, 32'h1002, 32'h0, 32'h3, 32'h0, 0, 8'h00, 0, 1'b0);
        send("R5", 32'h0000_0002, 8'h00, 16'h0007, 32'h100, 32'h1000, 32'h0, 32'h2001, 32'h0, 0, 8'h00, 0, 1'b0);
        // R6
        send("R6", 32'h0000_0002, 8'h00, 16'h0008, 32'h100, 32'h1000, 32'h0001_0000, 32'h2000, 32'h0, 0, 8'h00, 0, 1'b0);
        send("R6", 32'h0000_0002, 8'h00, 16'h0009, 32'h100, 32'h1000, 32'h0, 32'h2000, 32'h8000_0000, 0, 8'h00, 0, 1'b0);
        // R7: header outranks everything else
        send("R7", 32'h0000_00C2, 8'h07, 16'h000A, 32'h3, 32'h1, 32'hFFFF_0000, 32'h1, 32'h0, 0, 8'h00, 0, 1'b0);
        // R10 R11: mover failure with interrupt requested
        send("R10", 32'h0000_0002, 8'h00, 16'h00AA, 32'h40, 32'h80, 32'h0, 32'hC0, 32'h0, 1, 8'h80, 1, 1'b0);
        send("R10", 32'h0000_0000, 8'h00, 16'h00BB, 32'h40, 32'h80, 32'h0, 32'hC0, 32'h0, 1, 8'h05, 0, 1'b0);
        // R10: done and error in the same cycle
        send("R10", 32'h0000_0002, 8'h00, 16'h00CC, 32'h40, 32'h80, 32'h0, 32'hC0, 32'h0, 2, 8'h90, 3, 1'b0);
        // R12: response during launch and offer while waiting are ignored
        send("R12", 32'h0000_0002, 8'h00, 16'h00DD, 32'h20, 32'h400, 32'h12, 32'h800, 32'h34, 0, 8'h00, 3, 1'b1);

        repeat (3) @(negedge clk);
        chk(wb_exp_q.size() == 0, "R12", "writebacks outstanding", wb_exp_q.size(), 64'h0);
        chk(cmd_exp_q.size() == 0, "R8", "launches outstanding", cmd_exp_q.size(), 64'h0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule